// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block chooses, for every CPU in a cluster, the single interrupt that should be offered to that CPU. For each CPU it looks only at interrupts that are both enabled and pending for that CPU. Among those it takes the one with the smallest 8-bit priority value, because a smaller value means a more urgent interrupt. The chosen interrupt then has to pass two gates. The first is the CPU's priority mask, compared inclusively. The second is the priority of the interrupt the CPU is already servicing, compared strictly.

Each CPU gets two outputs: an interrupt request line and a highest-pending ID. When nothing qualifies, the ID output reads the spurious value 1023. Interrupt IDs below a banked boundary take their priority from a per-CPU copy. Higher IDs share one priority across all CPUs. A balanced comparison tree does the search in a single cycle. The result is held in one output register, so every output follows its inputs exactly one clock later.

Top module: `irq_prio_select`

## Requirements
- R1: Among the interrupts enabled and pending for a CPU, the one with the numerically smallest priority is selected.
- R2: When several candidates have the same smallest priority, the one with the lowest ID is selected.
- R3: A CPU with no interrupt both enabled and pending reports ID 1023 and keeps its request low.
- R4: The selected interrupt is reported as the highest-pending ID only if its priority is less than or equal to that CPU's 8-bit mask. Otherwise the ID reads 1023 and the request stays low.
- R5: The request asserts only if the reported interrupt's priority is strictly below the CPU's 9-bit running priority. An equal or higher value still reports the ID but keeps the request low.
- R6: While the global distributor enable is low, every CPU reports ID 1023 with its request low.
- R7: While a CPU's own interface enable is low, that CPU reports ID 1023 with its request low, and the other CPUs are unaffected.
- R8: For IDs below NUM_BANKED, the priority comes from the per-CPU bank at bit offset (cpu*NUM_BANKED+id)*8. For higher IDs it comes from the shared array at bit offset (id-NUM_BANKED)*8.
- R9: The enable bit and pending bit of a CPU/ID pair sit at bit cpu*NUM_IRQ+id of their vectors. Each CPU considers only its own bits.
- R10: During reset, and in the first cycle after it, all requests are low and all IDs read 1023. An input change is reflected at the outputs after exactly one rising clock edge.
- R11: A running priority of 0x100 means idle, so any reported interrupt raises the request. A running priority of 0 blocks every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dist_en_i | input | 1 | Global distributor enable |
| cpu_en_i | input | NUM_CPU | Per-CPU interface enable |
| en_i | input | NUM_CPU*NUM_IRQ | Enable bits, bit cpu*NUM_IRQ+id |
| pend_i | input | NUM_CPU*NUM_IRQ | Pending bits, bit cpu*NUM_IRQ+id |
| prio_bank_i | input | NUM_CPU*NUM_BANKED*8 | Per-CPU priorities for banked IDs |
| prio_shared_i | input | (NUM_IRQ-NUM_BANKED)*8 | Shared priorities for IDs at or above NUM_BANKED |
| mask_i | input | NUM_CPU*8 | Per-CPU priority mask |
| run_prio_i | input | NUM_CPU*9 | Per-CPU running priority, 0x100 means idle |
| irq_o | output | NUM_CPU | Per-CPU interrupt request |
| hppi_o | output | NUM_CPU*10 | Per-CPU highest-pending ID, 1023 when none |

## Verification
The block has only one register stage, so any fault in the tree or the gates appears at the ports exactly one cycle after the input pattern that exposes it. The fault shows either as a wrong ID or as a request at the wrong level. A tie rule broken in the tree shows up as a higher ID winning. A gate with the wrong strictness shows up only when the priority equals the mask or equals the running priority. The bench therefore aims directed cases at those exact equalities and at tied priorities that sit on both sides of the banked boundary. A long sweep over a small set of priority values then makes ties and boundary equalities common.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int unsigned PRIO_W = 8;
    localparam int unsigned RUN_W  = PRIO_W + 1;
    localparam int unsigned ID_W   = 10;

    localparam logic [ID_W-1:0]  SPURIOUS_ID = 10'd1023;
    localparam logic [RUN_W-1:0] IDLE_PRIO   = 9'h100;

    typedef struct packed {
        logic              vld;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   id;
    } cand_t;

endpackage

// File: rtl/irq_prio_tree.sv
module irq_prio_tree
    import irq_prio_pkg::*;
#(
    parameter int unsigned N = 64
) (
    input  logic [N-1:0]        cand_i,
    input  logic [N*PRIO_W-1:0] prio_i,
    output logic [RUN_W-1:0]    best_prio_o,
    output logic [ID_W-1:0]     best_id_o
);

    localparam int unsigned LEAVES = 1 << $clog2(N);
    localparam int unsigned NODES  = 2 * LEAVES - 1;

    // Heap-ordered tree: the left child always covers the lower IDs,
    // so keeping the left side on equal priority gives the lower ID.
    function automatic cand_t search(input logic [N-1:0] v,
                                     input logic [N*PRIO_W-1:0] p);
        cand_t node [NODES];
        cand_t a;
        cand_t b;
        for (int i = 0; i < int'(LEAVES); i++) begin
            if (i < int'(N)) begin
                node[LEAVES-1+i].vld  = v[i];
                node[LEAVES-1+i].prio = p[i*PRIO_W +: PRIO_W];
            end else begin
                node[LEAVES-1+i].vld  = 1'b0;
                node[LEAVES-1+i].prio = '1;
            end
            node[LEAVES-1+i].id = ID_W'(i);
        end
        for (int k = int'(LEAVES) - 2; k >= 0; k--) begin
            a = node[2*k+1];
            b = node[2*k+2];
            if (a.vld && (!b.vld || a.prio <= b.prio)) begin
                node[k] = a;
            end else if (b.vld) begin
                node[k] = b;
            end else begin
                node[k] = a;
            end
        end
        return node[0];
    endfunction

    cand_t root;

    always_comb begin
        root = search(cand_i, prio_i);
        if (root.vld) begin
            best_prio_o = {1'b0, root.prio};
            best_id_o   = root.id;
        end else begin
            best_prio_o = IDLE_PRIO;
            best_id_o   = SPURIOUS_ID;
        end
    end

endmodule

// File: rtl/irq_prio_gate.sv
module irq_prio_gate
    import irq_prio_pkg::*;
(
    input  logic              dist_en_i,
    input  logic              cpu_en_i,
    input  logic [RUN_W-1:0]  best_prio_i,
    input  logic [ID_W-1:0]   best_id_i,
    input  logic [PRIO_W-1:0] mask_i,
    input  logic [RUN_W-1:0]  run_prio_i,
    output logic              req_o,
    output logic [ID_W-1:0]   id_o
);

    logic open;
    logic recorded;

    always_comb begin
        open     = dist_en_i && cpu_en_i;
        // Stage one: inclusive compare against the mask.
        // An empty search yields 0x100, which no 8-bit mask admits.
        recorded = open && (best_prio_i <= {1'b0, mask_i});
        id_o     = recorded ? best_id_i : SPURIOUS_ID;
        // Stage two: strict compare against the running priority.
        req_o    = recorded && (best_prio_i < run_prio_i);
    end

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_CPU    = 2,
    parameter int unsigned NUM_IRQ    = 64,
    parameter int unsigned NUM_BANKED = 32
) (
    input  logic                                     clk_i,
    input  logic                                     rst_ni,
    input  logic                                     dist_en_i,
    input  logic [NUM_CPU-1:0]                       cpu_en_i,
    input  logic [NUM_CPU*NUM_IRQ-1:0]               en_i,
    input  logic [NUM_CPU*NUM_IRQ-1:0]               pend_i,
    input  logic [NUM_CPU*NUM_BANKED*PRIO_W-1:0]     prio_bank_i,
    input  logic [(NUM_IRQ-NUM_BANKED)*PRIO_W-1:0]   prio_shared_i,
    input  logic [NUM_CPU*PRIO_W-1:0]                mask_i,
    input  logic [NUM_CPU*RUN_W-1:0]                 run_prio_i,
    output logic [NUM_CPU-1:0]                       irq_o,
    output logic [NUM_CPU*ID_W-1:0]                  hppi_o
);

    localparam int unsigned NUM_SHARED = NUM_IRQ - NUM_BANKED;

    typedef struct packed {
        logic [NUM_CPU-1:0]           req;
        logic [NUM_CPU-1:0][ID_W-1:0] id;
    } sel_state_t;

    sel_state_t state_d, state_q;

    logic [NUM_CPU-1:0]           req_w;
    logic [NUM_CPU-1:0][ID_W-1:0] id_w;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NUM_IRQ-1:0]        cand;
        logic [NUM_IRQ*PRIO_W-1:0] prio_vec;
        logic [RUN_W-1:0]          best_prio;
        logic [ID_W-1:0]           best_id;

        assign cand = en_i[c*NUM_IRQ +: NUM_IRQ] & pend_i[c*NUM_IRQ +: NUM_IRQ];

        for (genvar i = 0; i < NUM_BANKED; i++) begin : g_bank
            assign prio_vec[i*PRIO_W +: PRIO_W] =
                prio_bank_i[(c*NUM_BANKED+i)*PRIO_W +: PRIO_W];
        end
        for (genvar j = 0; j < NUM_SHARED; j++) begin : g_shared
            assign prio_vec[(NUM_BANKED+j)*PRIO_W +: PRIO_W] =
                prio_shared_i[j*PRIO_W +: PRIO_W];
        end

        irq_prio_tree #(.N(NUM_IRQ)) u_tree (
            .cand_i      (cand),
            .prio_i      (prio_vec),
            .best_prio_o (best_prio),
            .best_id_o   (best_id)
        );

        irq_prio_gate u_gate (
            .dist_en_i   (dist_en_i),
            .cpu_en_i    (cpu_en_i[c]),
            .best_prio_i (best_prio),
            .best_id_i   (best_id),
            .mask_i      (mask_i[c*PRIO_W +: PRIO_W]),
            .run_prio_i  (run_prio_i[c*RUN_W +: RUN_W]),
            .req_o       (req_w[c]),
            .id_o        (id_w[c])
        );
    end

    always_comb begin
        state_d = state_q;
        for (int c = 0; c < int'(NUM_CPU); c++) begin
            state_d.req[c] = req_w[c];
            state_d.id[c]  = id_w[c];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.req <= '0;
            state_q.id  <= {NUM_CPU{SPURIOUS_ID}};
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_o  = state_q.req;
    assign hppi_o = state_q.id;

endmodule

// File: rtl/irq_prio_select_chk.sv
module irq_prio_select_chk
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_CPU = 2,
    parameter int unsigned NUM_IRQ = 64
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       dist_en_i,
    input logic [NUM_CPU-1:0]         cpu_en_i,
    input logic [NUM_CPU*NUM_IRQ-1:0] en_i,
    input logic [NUM_CPU*NUM_IRQ-1:0] pend_i,
    input logic [NUM_CPU*RUN_W-1:0]   run_prio_i,
    input logic [NUM_CPU-1:0]         irq_o,
    input logic [NUM_CPU*ID_W-1:0]    hppi_o
);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
        p_global_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !$past(dist_en_i) |-> (!irq_o[c] && hppi_o[c*ID_W +: ID_W] == SPURIOUS_ID));

        p_cpu_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !$past(cpu_en_i[c]) |-> (!irq_o[c] && hppi_o[c*ID_W +: ID_W] == SPURIOUS_ID));

        p_empty_spurious_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(en_i[c*NUM_IRQ +: NUM_IRQ] & pend_i[c*NUM_IRQ +: NUM_IRQ]) == '0)
            |-> (!irq_o[c] && hppi_o[c*ID_W +: ID_W] == SPURIOUS_ID));

        p_zero_running_blocks_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(run_prio_i[c*RUN_W +: RUN_W]) == '0) |-> !irq_o[c]);

        p_req_has_id_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[c] |-> (hppi_o[c*ID_W +: ID_W] < ID_W'(NUM_IRQ)));

        p_req_candidate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[c] |-> ($past(en_i[c*NUM_IRQ +: NUM_IRQ] & pend_i[c*NUM_IRQ +: NUM_IRQ]) != '0));
    end

endmodule

bind irq_prio_select irq_prio_select_chk #(
    .NUM_CPU (NUM_CPU),
    .NUM_IRQ (NUM_IRQ)
) u_chk (.*);

// File: tb/irq_prio_select_tb.sv
module irq_prio_select_tb;

    localparam int NC = 2;
    localparam int NI = 64;
    localparam int NB = 32;

    logic                   clk = 1'b0;
    logic                   rst_ni = 1'b0;
    logic                   dist_en;
    logic [NC-1:0]          cpu_en;
    logic [NC*NI-1:0]       en;
    logic [NC*NI-1:0]       pend;
    logic [NC*NB*8-1:0]     pbank;
    logic [(NI-NB)*8-1:0]   pshared;
    logic [NC*8-1:0]        mask;
    logic [NC*9-1:0]        runp;
    logic [NC-1:0]          irq;
    logic [NC*10-1:0]       hppi;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irq_prio_select #(.NUM_CPU(NC), .NUM_IRQ(NI), .NUM_BANKED(NB)) u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .dist_en_i(dist_en), .cpu_en_i(cpu_en),
        .en_i(en), .pend_i(pend), .prio_bank_i(pbank), .prio_shared_i(pshared),
        .mask_i(mask), .run_prio_i(runp), .irq_o(irq), .hppi_o(hppi)
    );

    task automatic clear_all();
        dist_en = 1'b1; cpu_en = '1; en = '0; pend = '0;
        pbank = '0; pshared = '0;
        for (int c = 0; c < NC; c++) begin
            mask[c*8 +: 8] = 8'hF0;
            runp[c*9 +: 9] = 9'h100;
        end
    endtask

    task automatic set_prio(int c, int id, logic [7:0] v);
        if (id < NB) pbank[(c*NB+id)*8 +: 8] = v;
        else         pshared[(id-NB)*8 +: 8] = v;
    endtask

    task automatic arm(int c, int id);
        en[c*NI+id] = 1'b1; pend[c*NI+id] = 1'b1;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    function automatic logic [7:0] prio_of(int c, int id);
        return (id < NB) ? pbank[(c*NB+id)*8 +: 8] : pshared[(id-NB)*8 +: 8];
    endfunction

    task automatic expect_out(int c, logic r, int id, string tag);
        n_chk++;
        if (irq[c] !== r || hppi[c*10 +: 10] !== 10'(id)) begin
            n_bad++;
            $display("FAIL %s cpu%0d: got req=%0d id=%0d, expected req=%0d id=%0d",
                     tag, c, irq[c], hppi[c*10 +: 10], r, id);
        end
    endtask

    // Independent arithmetic model of the selection rules.
    task automatic model(int c, output logic r, output int id);
        int bp = 256; int bi = 1023;
        r = 1'b0; id = 1023;
        for (int i = 0; i < NI; i++)
            if (en[c*NI+i] && pend[c*NI+i] && int'(prio_of(c, i)) < bp) begin
                bp = int'(prio_of(c, i)); bi = i;
            end
        if (dist_en && cpu_en[c] && bp <= int'(mask[c*8 +: 8])) begin
            id = bi;
            r  = (bp < int'(runp[c*9 +: 9]));
        end
    endtask

    initial begin
        #1500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic er; int eid;
        clear_all();
        step();
        expect_out(0, 1'b0, 1023, "R10 reset");
        expect_out(1, 1'b0, 1023, "R10 reset");
        rst_ni = 1'b1;
        step();
        expect_out(0, 1'b0, 1023, "R10 first cycle");

        // R1 lowest value wins, across bank and shared
        arm(0, 5); set_prio(0, 5, 8'h40);
        arm(0, 40); set_prio(0, 40, 8'h20);
        arm(0, 63); set_prio(0, 63, 8'h30);
        step();
        expect_out(0, 1'b1, 40, "R1");
        expect_out(1, 1'b0, 1023, "R9 other cpu empty");

        // R2 ties favour lower ID
        clear_all();
        arm(0, 7); set_prio(0, 7, 8'h10);
        arm(0, 50); set_prio(0, 50, 8'h10);
        arm(1, 34); arm(1, 33); set_prio(0, 33, 8'h60); set_prio(0, 34, 8'h60);
        step();
        expect_out(0, 1'b1, 7, "R2 bank vs shared tie");
        expect_out(1, 1'b1, 33, "R2 shared tie");

        // R3 no candidate
        clear_all(); en = '1; step();
        expect_out(0, 1'b0, 1023, "R3");
        expect_out(1, 1'b0, 1023, "R3");

        // R4 mask inclusive
        clear_all(); arm(0, 45); set_prio(0, 45, 8'h80); mask[7:0] = 8'h80; step();
        expect_out(0, 1'b1, 45, "R4 equal mask");
        mask[7:0] = 8'h7F; step();
        expect_out(0, 1'b0, 1023, "R4 above mask");
        mask[7:0] = 8'hFF; set_prio(0, 45, 8'hFF); step();
        expect_out(0, 1'b1, 45, "R4 max mask");

        // R5 strict running compare
        set_prio(0, 45, 8'h80); runp[8:0] = 9'h080; step();
        expect_out(0, 1'b0, 45, "R5 equal running");
        runp[8:0] = 9'h081; step();
        expect_out(0, 1'b1, 45, "R5 below running");
        runp[8:0] = 9'h000; step();
        expect_out(0, 1'b0, 45, "R11 running zero");

        // R11 idle running priority
        clear_all(); arm(1, 60); set_prio(0, 60, 8'hF0); step();
        expect_out(1, 1'b1, 60, "R11 idle");

        // R6 / R7 enables
        arm(0, 60); dist_en = 1'b0; step();
        expect_out(0, 1'b0, 1023, "R6");
        expect_out(1, 1'b0, 1023, "R6");
        dist_en = 1'b1; cpu_en = 2'b01; step();
        expect_out(0, 1'b1, 60, "R7 enabled cpu");
        expect_out(1, 1'b0, 1023, "R7 disabled cpu");

        // R8 banked priorities
        clear_all();
        arm(0, 3); arm(1, 3); set_prio(0, 3, 8'h80); set_prio(1, 3, 8'h10);
        arm(0, 40); arm(1, 40); set_prio(0, 40, 8'h50);
        step();
        expect_out(0, 1'b1, 40, "R8 cpu0");
        expect_out(1, 1'b1, 3, "R8 cpu1");

        // R9 enable is per CPU
        clear_all(); en[NI+20] = 1'b1; pend[20] = 1'b1; pend[NI+20] = 1'b1; step();
        expect_out(0, 1'b0, 1023, "R9 cpu0 not enabled");
        expect_out(1, 1'b1, 20, "R9 cpu1");

        // R10 one-cycle latency
        pend[NI+20] = 1'b0; #1;
        expect_out(1, 1'b1, 20, "R10 before edge");
        step();
        expect_out(1, 1'b0, 1023, "R10 after edge");

        // Sweep with few priority values so ties and equalities are common
        for (int it = 0; it < 3000; it++) begin
            dist_en = ($urandom_range(15) != 0);
            cpu_en  = ($urandom_range(7) != 0) ? 2'b11 : 2'($urandom_range(3));
            for (int k = 0; k < NC*NI; k++) begin
                en[k]   = ($urandom_range(3) != 0);
                pend[k] = ($urandom_range(5) == 0);
            end
            for (int k = 0; k < NC*NB; k++) pbank[k*8 +: 8] = 8'($urandom_range(7) * 32);
            for (int k = 0; k < NI-NB; k++) pshared[k*8 +: 8] = 8'($urandom_range(7) * 32);
            for (int c = 0; c < NC; c++) begin
                mask[c*8 +: 8] = 8'($urandom_range(8) * 32 - (($urandom_range(1)==1) ? 0 : 1));
                runp[c*9 +: 9] = 9'($urandom_range(8) * 32);
            end
            step();
            for (int c = 0; c < NC; c++) begin
                model(c, er, eid);
                expect_out(c, er, eid, "R1 R2 R4 R5 sweep");
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule